// File: doc/BRIEF.md
# SPI Slave Receive Path with Ready Throttling

This block is the receive side of a serial slave used while a chip loads its boot image from an external host. The host clocks data in SPI mode 0 (data sampled on the rising serial clock while the active-low select is held low, most significant bit first). The block packs the bits into words of 8, 16 or 32 bits and keeps them in a fixed 64-bit store, so it holds 8, 4 or 2 words depending on the word size. An internal consumer drains the words through a parallel read port in arrival order.

The store behaves as two halves that trade places. The host fills one half while the consumer empties the other, and writing moves on to the second half once the first is full. A ready output lets a host that sends one byte at a time and samples ready after each byte slow down before the store overflows. Ready drops when three quarters of the current capacity or more is occupied. A word that arrives while the store is full is dropped and recorded in a sticky overflow flag.

The serial pins are brought into the system clock domain through a two-stage synchronizer. The serial clock must be at least four times slower than the system clock.

Top module: `spi_rx_ready`

## Requirements
- R1: After reset, `ready` is 1, `rd_valid` is 0 and `overflow` is 0.
- R2: With word size 8 (`cfg_wsize` = 0 or 3), each group of 8 bits is taken MSB first on rising `spi_sck` while `spi_cs_n` is low. The word is presented right-justified on `rd_data`, and bits 31:8 are zero.
- R3: With `cfg_wsize` = 1, words are 16 bits. With `cfg_wsize` = 2, words are 32 bits. Both use the same bit order as R2, and unused upper bits of `rd_data` read as zero.
- R4: The store holds at most 8, 4 or 2 words for word sizes 8, 16 or 32. A word completed while the store is full is dropped and sets `overflow`.
- R5: `ready` is 0 when the stored word count is at least 6, 3 or 2 (word size 8, 16, 32) and 1 otherwise. It follows the count one clock later.
- R6: Words leave the read port in arrival order. This includes the case where writing wraps from the second half of the store back into the first. A one-cycle `rd_en` pulse with `rd_valid` high removes exactly one word.
- R7: Bits of an incomplete word are discarded when `spi_cs_n` rises. The next word starts from a clean bit count.
- R8: `cfg_wsize` is taken only while `spi_cs_n` is high. Changing it while `spi_cs_n` is low has no effect. When a changed value is taken, the store is emptied.
- R9: `overflow` stays set until a one-cycle `ovf_clr` pulse clears it.
- R10: A `rd_en` pulse while `rd_valid` is 0 changes nothing. A word received afterwards is read back unaltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| cfg_wsize | input | 2 | Word size: 0 = 8, 1 = 16, 2 = 32, 3 = 8 bits |
| rd_en | input | 1 | Pop strobe for the oldest word |
| rd_data | output | 32 | Oldest stored word, right-justified |
| rd_valid | output | 1 | At least one word is stored |
| ready | output | 1 | Host may send more data |
| ovf_clr | input | 1 | Clears the overflow flag |
| overflow | output | 1 | Sticky: a word was dropped because the store was full |

## Verification
A wrong fill count shows up at `ready` one clock after the word that should have moved it across the threshold. It also shows up later as a missing or extra word when the store is drained. A read or write pointer that wraps at the wrong place gives out-of-order or corrupted data on the first read after writing wraps across the halves. A shift counter that keeps stale bits shifts every later word, so the first word read after an aborted transfer is wrong. The bench compares every word it pops against a queue of words it sent, and it samples `ready` and `overflow` after each word completes.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    localparam int STORE_W    = 64;
    localparam int MAX_WORD_W = 32;
    localparam int MAX_ENT    = STORE_W / 8;
    localparam int PTR_W      = $clog2(MAX_ENT);
    localparam int LVL_W      = PTR_W + 1;
    localparam int BCNT_W     = $clog2(MAX_WORD_W);
    localparam int SH_W       = $clog2(STORE_W);

    typedef enum logic [1:0] {
        WS_8  = 2'd0,
        WS_16 = 2'd1,
        WS_32 = 2'd2
    } wsize_e;

    typedef struct packed {
        logic                  vld;
        logic [MAX_WORD_W-1:0] data;
    } rx_word_t;

    function automatic wsize_e ws_decode(input logic [1:0] code);
        case (code)
            2'd1:    return WS_16;
            2'd2:    return WS_32;
            default: return WS_8;
        endcase
    endfunction

    function automatic logic [5:0] ws_bits(input wsize_e w);
        case (w)
            WS_16:   return 6'd16;
            WS_32:   return 6'd32;
            default: return 6'd8;
        endcase
    endfunction

    function automatic logic [MAX_WORD_W-1:0] ws_mask(input wsize_e w);
        logic [63:0] m;
        m = (64'd1 << ws_bits(w)) - 64'd1;
        return m[MAX_WORD_W-1:0];
    endfunction

    // number of words the fixed store holds at this word size
    function automatic logic [LVL_W-1:0] ws_cap(input wsize_e w);
        return LVL_W'(STORE_W / int'(ws_bits(w)));
    endfunction

    // three-quarter mark: 6 of 8, 3 of 4, 2 of 2
    function automatic logic [LVL_W-1:0] ws_thr(input wsize_e w);
        return ws_cap(w) - (ws_cap(w) >> 2);
    endfunction
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
    import spi_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_s,
    input  logic     cs_n_s,
    input  logic     mosi_s,
    input  logic     flush,
    input  wsize_e   ws,
    output rx_word_t word_o
);
    logic                  sck_d;
    logic [MAX_WORD_W-1:0] sr;
    logic [BCNT_W-1:0]     cnt;
    logic                  sck_rise;
    logic                  last_bit;
    logic [MAX_WORD_W-1:0] sr_nxt;

    assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
    assign last_bit = (cnt == BCNT_W'(ws_bits(ws) - 6'd1));
    assign sr_nxt   = {sr[MAX_WORD_W-2:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b0;
            sr     <= '0;
            cnt    <= '0;
            word_o <= '0;
        end else begin
            sck_d      <= sck_s;
            word_o.vld <= 1'b0;
            if (cs_n_s || flush) begin
                cnt <= '0;
            end else if (sck_rise) begin
                sr <= sr_nxt;
                if (last_bit) begin
                    cnt         <= '0;
                    word_o.vld  <= 1'b1;
                    word_o.data <= sr_nxt & ws_mask(ws);
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_rx_store.sv
// Ring over a fixed 64-bit store. Pointer slots below cap/2 form one half,
// the rest the other, so the writer fills one half while the reader drains
// the other and wraps back: the ping-pong pair falls out of the ring order.
module spi_rx_store
    import spi_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  wsize_e                ws,
    input  rx_word_t              wr_i,
    input  logic                  rd_en,
    output logic [MAX_WORD_W-1:0] rd_data,
    output logic                  rd_valid,
    output logic [LVL_W-1:0]      level,
    output logic                  drop_o
);
    logic [STORE_W-1:0] mem;
    logic [PTR_W-1:0]   wp, rp;
    logic [LVL_W-1:0]   cnt;
    logic [LVL_W-1:0]   cap;
    logic               full, push, pop;
    logic [SH_W-1:0]    wsh, rsh;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p,
                                                  input logic [LVL_W-1:0] c);
        return (LVL_W'(p) == c - 1'b1) ? '0 : p + 1'b1;
    endfunction

    assign cap  = ws_cap(ws);
    assign full = (cnt == cap);
    assign push = wr_i.vld && !full && !flush;
    assign pop  = rd_en && (cnt != '0) && !flush;
    assign wsh  = SH_W'(int'(wp) * int'(ws_bits(ws)));
    assign rsh  = SH_W'(int'(rp) * int'(ws_bits(ws)));

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem <= (mem & ~(STORE_W'(ws_mask(ws)) << wsh))
                     | (STORE_W'(wr_i.data & ws_mask(ws)) << wsh);
                wp  <= ptr_inc(wp, cap);
            end
            if (pop) rp <= ptr_inc(rp, cap);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign rd_data  = MAX_WORD_W'(mem >> rsh) & ws_mask(ws);
    assign rd_valid = (cnt != '0);
    assign level    = cnt;
    assign drop_o   = wr_i.vld && full && !flush;
endmodule

// File: rtl/spi_rx_ready.sv
module spi_rx_ready
    import spi_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  spi_sck,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    input  logic [1:0]            cfg_wsize,
    input  logic                  rd_en,
    output logic [MAX_WORD_W-1:0] rd_data,
    output logic                  rd_valid,
    output logic                  ready,
    input  logic                  ovf_clr,
    output logic                  overflow
);
    logic [2:0]       pins_s;
    logic             sck_s, cs_n_s, mosi_s;
    wsize_e           ws_q;
    logic             flush;
    rx_word_t         wr_word;
    logic [LVL_W-1:0] level;
    logic             drop;

    spi_rx_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_sck, spi_cs_n, spi_mosi}),
        .q  (pins_s)
    );
    assign {sck_s, cs_n_s, mosi_s} = pins_s;

    // word size is only taken while the host is deselected
    assign flush = cs_n_s && (ws_decode(cfg_wsize) != ws_q);

    always_ff @(posedge clk) begin
        if (rst) ws_q <= WS_8;
        else if (flush) ws_q <= ws_decode(cfg_wsize);
    end

    spi_rx_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .sck_s (sck_s),
        .cs_n_s(cs_n_s),
        .mosi_s(mosi_s),
        .flush (flush),
        .ws    (ws_q),
        .word_o(wr_word)
    );

    spi_rx_store u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .ws      (ws_q),
        .wr_i    (wr_word),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .level   (level),
        .drop_o  (drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready    <= 1'b1;
            overflow <= 1'b0;
        end else begin
            ready    <= (level < ws_thr(ws_q));
            overflow <= (overflow & ~ovf_clr) | drop;
        end
    end
endmodule

// File: rtl/spi_rx_ready_chk.sv
module spi_rx_ready_chk
    import spi_rx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ready,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             overflow,
    input logic             ovf_clr,
    input logic             flush,
    input logic             wr_vld,
    input logic [LVL_W-1:0] level,
    input wsize_e           ws
);
    assert_ready_thr_R5: assert property (@(posedge clk) disable iff (rst)
        ready == ($past(level) < ws_thr($past(ws))));

    assert_level_cap_R4: assert property (@(posedge clk) disable iff (rst)
        level <= ws_cap(ws));

    assert_ovf_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> ($past(level) == ws_cap($past(ws))));

    assert_pop_one_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_valid && !wr_vld && !flush) |=> (level == $past(level) - 1'b1));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);

    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0 && !rd_valid));
endmodule

bind spi_rx_ready spi_rx_ready_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .ready   (ready),
    .rd_en   (rd_en),
    .rd_valid(rd_valid),
    .overflow(overflow),
    .ovf_clr (ovf_clr),
    .flush   (flush),
    .wr_vld  (wr_word.vld),
    .level   (level),
    .ws      (ws_q)
);

// File: tb/spi_rx_ready_tb.sv
module spi_rx_ready_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic [1:0]  cfg_wsize = 2'd0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        ready;
    logic        ovf_clr = 1'b0;
    logic        overflow;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q[$];
    bit          mon_en = 1'b0;
    bit          force_rd = 1'b0;
    int          popped = 0;
    int          mon_limit = 0;
    string       mon_req = "";

    always #5 clk = ~clk;

    spi_rx_ready dut_i (
        .clk      (clk),
        .rst      (rst),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .cfg_wsize(cfg_wsize),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .ready    (ready),
        .ovf_clr  (ovf_clr),
        .overflow (overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: shifts one word MSB first; queues it when it should be stored
    task automatic send(input logic [31:0] d, input int nbits, input bit keep);
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_mosi = d[i];
            tick(4);
            spi_sck = 1'b1;
            tick(4);
            spi_sck = 1'b0;
        end
        if (keep) exp_q.push_back(d);
        tick(8);
    endtask

    task automatic sel(input bit v);
        spi_cs_n = v;
        tick(6);
    endtask

    // monitor: pops the read port and compares each word with the queue
    always @(negedge clk) begin
        rd_en <= force_rd;
        if (mon_en && rd_valid && !rd_en && popped < mon_limit) begin
            check(mon_req, rd_data, (exp_q.size() != 0) ? exp_q.pop_front() : 32'hxxxx_xxxx);
            rd_en  <= 1'b1;
            popped++;
        end
    end

    task automatic drain(input string req, input int n);
        popped    = 0;
        mon_limit = n;
        mon_req   = req;
        mon_en    = 1'b1;
        for (int t = 0; t < 100 && popped < n; t++) tick(1);
        tick(4);
        mon_en = 1'b0;
        check({req, " count"}, 32'(popped), 32'(n));
    endtask

    task automatic pulse_clr();
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        check("R1 ready", 32'(ready), 32'd1);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 overflow", 32'(overflow), 32'd0);

        // 8-bit words: threshold 6 of 8
        sel(0);
        for (int i = 0; i < 5; i++) send(32'(8'hA1 + i), 8, 1);
        check("R5 ready at 5 of 8", 32'(ready), 32'd1);
        send(32'h5A, 8, 1);
        check("R5 ready at 6 of 8", 32'(ready), 32'd0);
        send(32'hC3, 8, 1);
        send(32'h81, 8, 1);
        check("R4 no overflow at 8", 32'(overflow), 32'd0);
        send(32'hEE, 8, 0);
        check("R4 overflow on 9th byte", 32'(overflow), 32'd1);
        sel(1);
        drain("R2 byte data", 8);
        check("R5 ready after drain", 32'(ready), 32'd1);

        // R6 wrap across halves
        sel(0);
        for (int i = 0; i < 5; i++) send(32'(8'h10 + i), 8, 1);
        drain("R6 partial drain", 3);
        for (int i = 0; i < 4; i++) send(32'(8'h60 + i), 8, 1);
        check("R5 ready at 6 after wrap", 32'(ready), 32'd0);
        drain("R6 order after wrap", 6);

        // R9 sticky overflow and clear
        check("R9 overflow still set", 32'(overflow), 32'd1);
        pulse_clr();
        check("R9 overflow cleared", 32'(overflow), 32'd0);

        // R10 read strobe on empty store
        force_rd = 1'b1;
        tick(1);
        force_rd = 1'b0;
        tick(2);
        check("R10 empty after stray read", 32'(rd_valid), 32'd0);
        send(32'h5C, 8, 1);
        drain("R10 word after stray read", 1);

        // R7 partial word dropped on deselect
        send(32'h1F, 5, 0);
        sel(1);
        tick(4);
        check("R7 partial word discarded", 32'(rd_valid), 32'd0);
        sel(0);
        send(32'h3C, 8, 1);
        drain("R7 next word clean", 1);

        // R8 word size ignored while selected, flush when taken
        send(32'h11, 8, 1);
        cfg_wsize = 2'd1;
        send(32'h22, 8, 1);
        drain("R8 size held while selected", 2);
        send(32'h33, 8, 0);
        check("R8 word pending before flush", 32'(rd_valid), 32'd1);
        sel(1);
        tick(4);
        check("R8 flushed on size change", 32'(rd_valid), 32'd0);
        check("R8 ready after flush", 32'(ready), 32'd1);

        // 16-bit words: capacity 4, threshold 3
        sel(0);
        send(32'hBEEF, 16, 1);
        send(32'h1234, 16, 1);
        check("R5 ready at 2 of 4", 32'(ready), 32'd1);
        send(32'hCAFE, 16, 1);
        check("R5 ready at 3 of 4", 32'(ready), 32'd0);
        send(32'h0F0F, 16, 1);
        check("R4 no overflow at 4 of 4", 32'(overflow), 32'd0);
        send(32'h7777, 16, 0);
        check("R4 overflow at 16-bit", 32'(overflow), 32'd1);
        sel(1);
        drain("R3 16-bit data", 4);

        // 32-bit words: capacity 2, threshold 2
        cfg_wsize = 2'd2;
        tick(4);
        pulse_clr();
        check("R9 cleared before 32-bit", 32'(overflow), 32'd0);
        sel(0);
        send(32'hDEADBEEF, 32, 1);
        check("R5 ready at 1 of 2", 32'(ready), 32'd1);
        send(32'h01234567, 32, 1);
        check("R5 ready at 2 of 2", 32'(ready), 32'd0);
        send(32'h89ABCDEF, 32, 0);
        check("R4 overflow at 32-bit", 32'(overflow), 32'd1);
        sel(1);
        drain("R3 32-bit data", 2);
        check("R9 overflow held after reads", 32'(overflow), 32'd1);
        check("R5 ready when empty", 32'(ready), 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule